// File: doc/BRIEF.md
# Receive Character FIFO with Fill Trigger and Idle Timeout

This block buffers characters coming out of an asynchronous serial deserializer before the host picks them up. It holds up to sixteen entries, and each entry keeps the data byte together with that character's parity, framing and break flags. The host sees the oldest entry at the head of the queue. A read strobe removes that entry. A separate status-read strobe acknowledges the error flags.

Two conditions tell the host that it should read. The first is a fill-level indication, raised when the queue reaches a threshold the host selects. The second is an idle timeout, raised when data has been waiting for a number of bit times that depends on the word length. The block also produces the status bits: data ready, overrun, and a sticky error summary. An active-low ready pin has two signalling modes: it can follow "any data held", or it can latch on the trigger level or the timeout.

Top module: `rx_char_fifo`

## Requirements
- R1: `trig_sel` selects the fill threshold: 0→1, 1→4, 2→8, 3→14 characters. `avail` is high exactly while the stored count is at or above the threshold, so it drops as soon as the count falls below it.
- R2: `word_len` encodes 5,6,7,8 data bits as 0,1,2,3. `timeout` rises once the FIFO is non-empty and `4*(word_len+5)+12` pulses of `bit_tick` have been counted since the last restart. With 7-bit words that is 40 pulses.
- R3: `timeout` is never high while the FIFO is empty, and `bit_tick` pulses are not counted then. The count restarts on every `char_valid` strobe (given at the centre of the stop bit) and on every head read that removes an entry.
- R4: A `char_valid` strobe that arrives while 16 entries are stored sets `overrun` and is discarded. The stored entries and the count stay unchanged, and `overrun` stays set until a status read.
- R5: A `stat_rd` pulse clears `overrun` and `fifo_err`, and hides the head entry's error flags until a new entry becomes the head.
- R6: `head_perr`, `head_ferr` and `head_brk` report the flags stored with the entry currently at the head. They are bit 8, bit 9 and bit 10 of the 11-bit entry, above the 8-bit data.
- R7: `fifo_err` is set when a character that carries a parity, framing or break flag is stored. It stays set until `stat_rd`.
- R8: A character strobed with `char_brk` is stored as one entry with data 0x00 and its break flag set, whatever `char_data` carries.
- R9: `data_ready` is high exactly while at least one entry is stored.
- R10: A one-cycle `clr` pulse empties the FIFO and resets its pointers. The next stored character becomes the head.
- R11: With `rdy_mode`=0, `rxrdy_n` is low while any entry is held. With `rdy_mode`=1, it goes low when `avail` or `timeout` is reached and stays low until the FIFO is empty. In both modes it is high when the FIFO is empty.
- R12: `rd_pop` removes the head entry so that the entries come out in arrival order. `rd_pop` while the FIFO is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| char_valid | input | 1 | Character complete strobe from the deserializer |
| char_data | input | 8 | Received data byte |
| char_perr | input | 1 | Parity error for this character |
| char_ferr | input | 1 | Framing error for this character |
| char_brk | input | 1 | Character is a line break |
| bit_tick | input | 1 | One pulse per serial bit time |
| rd_pop | input | 1 | Host read of the head entry |
| stat_rd | input | 1 | Host read of line status |
| clr | input | 1 | Clear the FIFO (single-cycle command) |
| trig_sel | input | 2 | Fill threshold select |
| word_len | input | 2 | Programmed word length code |
| rdy_mode | input | 1 | Ready pin signalling mode |
| head_data | output | 8 | Data of the head entry |
| head_perr | output | 1 | Parity flag of the head entry |
| head_ferr | output | 1 | Framing flag of the head entry |
| head_brk | output | 1 | Break flag of the head entry |
| data_ready | output | 1 | At least one entry stored |
| overrun | output | 1 | Character lost because the FIFO was full |
| fifo_err | output | 1 | Sticky summary of stored errors |
| avail | output | 1 | Fill level at or above the threshold |
| timeout | output | 1 | Data idle for the timeout length |
| rxrdy_n | output | 1 | Receive ready, active low |

## Verification
The hardest situations to reach from the ports are the edges of the timeout window and the overrun. The timeout must stay low one tick before the limit and rise exactly on the limit. It must also be shown to restart when a new character arrives part-way through the window. The bench gets there by sending an exact number of single-cycle `bit_tick` pulses between strobes. For overrun, the bench first fills all sixteen entries through the scoreboard driver and then sends a marker character. Draining the queue afterwards shows that the marker never entered.

// File: rtl/rx_char_fifo.sv
module rx_char_fifo #(
  parameter int DEPTH = 16,
  parameter int TW    = 6,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       char_valid,
  input  logic [7:0] char_data,
  input  logic       char_perr,
  input  logic       char_ferr,
  input  logic       char_brk,
  input  logic       bit_tick,
  input  logic       rd_pop,
  input  logic       stat_rd,
  input  logic       clr,
  input  logic [1:0] trig_sel,
  input  logic [1:0] word_len,
  input  logic       rdy_mode,
  output logic [7:0] head_data,
  output logic       head_perr,
  output logic       head_ferr,
  output logic       head_brk,
  output logic       data_ready,
  output logic       overrun,
  output logic       fifo_err,
  output logic       avail,
  output logic       timeout,
  output logic       rxrdy_n
);

  logic [10:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, thr;
  logic [TW-1:0] to_cnt, to_lim;
  logic          hd_ack, latched;

  wire empty  = (cnt == '0);
  wire full   = (cnt == CW'(DEPTH));
  wire wr_ok  = char_valid & ~full & ~clr;
  wire rd_ok  = rd_pop & ~empty & ~clr;
  wire in_err = char_perr | char_ferr | char_brk;

  always_comb begin
    case (trig_sel)
      2'd0:    thr = CW'(1);
      2'd1:    thr = CW'(4);
      2'd2:    thr = CW'(8);
      default: thr = CW'(14);
    endcase
  end

  assign to_lim     = TW'(4 * (32'(word_len) + 5) + 12);
  assign data_ready = ~empty;
  assign avail      = (cnt >= thr);
  assign timeout    = ~empty & (to_cnt >= to_lim);
  assign head_data  = mem[rp][7:0];
  assign head_perr  = ~empty & ~hd_ack & mem[rp][8];
  assign head_ferr  = ~empty & ~hd_ack & mem[rp][9];
  assign head_brk   = ~empty & ~hd_ack & mem[rp][10];
  assign rxrdy_n    = rdy_mode ? ~(~empty & (avail | timeout | latched)) : empty;

  always_ff @(posedge clk)
    if (wr_ok) mem[wp] <= {char_brk, char_ferr, char_perr, char_brk ? 8'h00 : char_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
      overrun <= 1'b0; fifo_err <= 1'b0; hd_ack <= 1'b0;
      to_cnt <= '0; latched <= 1'b0;
    end else begin
      if (clr) begin
        wp <= '0; rp <= '0; cnt <= '0;
      end else begin
        if (wr_ok) wp <= wp + 1'b1;
        if (rd_ok) rp <= rp + 1'b1;
        cnt <= cnt + CW'(wr_ok) - CW'(rd_ok);
      end

      if (char_valid & full & ~clr) overrun <= 1'b1;
      else if (stat_rd)             overrun <= 1'b0;

      if (wr_ok & in_err)  fifo_err <= 1'b1;
      else if (stat_rd)    fifo_err <= 1'b0;

      if (clr | rd_ok | (wr_ok & empty)) hd_ack <= 1'b0;
      else if (stat_rd)                  hd_ack <= 1'b1;

      if (clr | empty | char_valid | rd_ok) to_cnt <= '0;
      else if (bit_tick & (to_cnt < to_lim)) to_cnt <= to_cnt + 1'b1;

      latched <= ~empty & (avail | timeout | latched);
    end
  end

  p_no_store_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    full && char_valid && !clr && !rd_pop |=> cnt == CW'(DEPTH));

  p_ovr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !stat_rd |=> overrun);

  p_clear_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !data_ready);

  p_to_from_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) && $stable(word_len) |-> $past(bit_tick));

  p_trig_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
    trig_sel == 2'd0 |-> avail == data_ready);

  p_last_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ok && cnt == CW'(1) && !char_valid |=> rxrdy_n);

endmodule

// File: tb/rx_char_fifo_bench.sv
module rx_char_fifo_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic char_valid = 0, char_perr = 0, char_ferr = 0, char_brk = 0;
  logic [7:0] char_data = 0;
  logic bit_tick = 0, rd_pop = 0, stat_rd = 0, clr = 0, rdy_mode = 0;
  logic [1:0] trig_sel = 0, word_len = 0;
  logic [7:0] head_data;
  logic head_perr, head_ferr, head_brk, data_ready, overrun, fifo_err, avail, timeout, rxrdy_n;

  int total = 0, failed = 0;
  logic [10:0] q[$];
  bit ack = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_char_fifo u_rx_char_fifo (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input bit p = 0, input bit f = 0, input bit b = 0);
    char_valid = 1; char_data = d; char_perr = p; char_ferr = f; char_brk = b;
    if (q.size() < 16) begin
      if (q.size() == 0) ack = 0;
      q.push_back({b, f, p, b ? 8'h00 : d});
    end
    @(negedge clk);
    char_valid = 0; char_perr = 0; char_ferr = 0; char_brk = 0;
  endtask

  task automatic pop(input string tag);
    logic [10:0] e;
    e = q.pop_front();
    chk(head_data == e[7:0], {tag, " data"}, head_data, e[7:0]);
    chk({head_brk, head_ferr, head_perr} == (ack ? 3'b000 : e[10:8]), {tag, " flags"},
        {head_brk, head_ferr, head_perr}, ack ? 3'b000 : e[10:8]);
    rd_pop = 1; @(negedge clk); rd_pop = 0;
    ack = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1; @(negedge clk); bit_tick = 0;
    end
  endtask

  task automatic status_read();
    stat_rd = 1; @(negedge clk); stat_rd = 0;
    ack = 1;
  endtask

  task automatic drain(input string tag);
    while (q.size() > 0) pop(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failed++; total++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!data_ready && rxrdy_n && !overrun && !fifo_err && !avail && !timeout, "reset R9 R11",
        {data_ready, rxrdy_n, overrun, fifo_err, avail, timeout}, 6'b010000);

    // R1 thresholds
    trig_sel = 1;
    push(8'h11); push(8'h22); push(8'h33);
    chk(!avail, "R1 sel1 at 3", avail, 0);
    chk(data_ready, "R9 set on store", data_ready, 1);
    push(8'h44);
    chk(avail, "R1 sel1 at 4", avail, 1);
    pop("R12");
    chk(!avail, "R1 clears below 4", avail, 0);
    for (int i = 0; i < 11; i++) push(8'h50 + 8'(i));
    trig_sel = 3; #1;
    chk(avail, "R1 sel3 at 14", avail, 1);
    pop("R12");
    chk(!avail, "R1 sel3 at 13", avail, 0);
    trig_sel = 2; #1;
    chk(avail, "R1 sel2 at 13", avail, 1);
    while (q.size() > 7) pop("R12");
    chk(!avail, "R1 sel2 at 7", avail, 0);
    trig_sel = 0; #1;
    chk(avail, "R1 sel0 at 7", avail, 1);
    drain("R12");
    chk(!data_ready, "R9 clears on empty", data_ready, 0);

    // R12 pop on empty ignored
    rd_pop = 1; @(negedge clk); rd_pop = 0;
    chk(!data_ready, "R12 empty pop", data_ready, 0);
    push(8'hA5);
    chk(head_data == 8'hA5, "R12 head after empty pop", head_data, 8'hA5);
    drain("R12");

    // R11 ready modes
    rdy_mode = 0; push(8'h01);
    chk(!rxrdy_n, "R11 mode0 one char", rxrdy_n, 0);
    rdy_mode = 1; trig_sel = 1; #1;
    chk(rxrdy_n, "R11 mode1 below trigger", rxrdy_n, 1);
    push(8'h02); push(8'h03); push(8'h04);
    chk(!rxrdy_n, "R11 mode1 at trigger", rxrdy_n, 0);
    pop("R11");
    chk(!rxrdy_n, "R11 mode1 held below trigger", rxrdy_n, 0);
    drain("R11");
    chk(rxrdy_n, "R11 mode1 empty", rxrdy_n, 1);

    // R2/R3 timeout
    word_len = 2; trig_sel = 3;
    push(8'h70);
    ticks(39);
    chk(!timeout, "R2 39 ticks", timeout, 0);
    chk(rxrdy_n, "R11 mode1 before timeout", rxrdy_n, 1);
    ticks(1);
    chk(timeout, "R2 40 ticks", timeout, 1);
    chk(!rxrdy_n, "R11 mode1 on timeout", rxrdy_n, 0);
    drain("R3");
    chk(!timeout, "R3 empty after pop", timeout, 0);
    ticks(50);
    chk(!timeout, "R3 empty no count", timeout, 0);
    push(8'h71); ticks(20); push(8'h72); ticks(39);
    chk(!timeout, "R3 restart on char", timeout, 0);
    ticks(1);
    chk(timeout, "R3 fires after restart", timeout, 1);
    pop("R3");
    chk(!timeout, "R3 restart on read", timeout, 0);
    drain("R3");
    word_len = 0;
    push(8'h73); ticks(31);
    chk(!timeout, "R2 5-bit 31 ticks", timeout, 0);
    ticks(1);
    chk(timeout, "R2 5-bit 32 ticks", timeout, 1);
    drain("R2");

    // R4/R5 overrun
    for (int i = 0; i < 16; i++) push(8'h80 + 8'(i));
    chk(!overrun, "R4 full no overrun", overrun, 0);
    push(8'hEE);
    chk(overrun, "R4 overrun set", overrun, 1);
    @(negedge clk);
    chk(overrun, "R4 overrun sticky", overrun, 1);
    drain("R4");
    chk(!data_ready, "R4 extra not stored", data_ready, 0);
    status_read();
    chk(!overrun, "R5 overrun cleared", overrun, 0);

    // R6/R7/R5 errors
    push(8'hC1, 1, 0, 0); push(8'hC2, 0, 1, 0); push(8'hC3);
    chk(head_perr && !head_ferr, "R6 head parity", {head_ferr, head_perr}, 2'b01);
    chk(fifo_err, "R7 summary set", fifo_err, 1);
    status_read();
    chk(!fifo_err, "R5 summary cleared", fifo_err, 0);
    chk(!head_perr, "R5 head flag acked", head_perr, 0);
    pop("R6");
    chk(head_ferr && !head_perr, "R6 next head framing", {head_ferr, head_perr}, 2'b10);
    drain("R6");

    // R8 break
    push(8'h5A, 0, 1, 1);
    chk(head_data == 8'h00 && head_brk, "R8 break zero", {head_brk, head_data}, 9'h100);
    chk(fifo_err, "R7 break sets summary", fifo_err, 1);
    drain("R8");
    status_read();

    // R10 clear
    push(8'hD1); push(8'hD2); push(8'hD3);
    clr = 1; @(negedge clk); clr = 0;
    q.delete();
    chk(!data_ready && rxrdy_n, "R10 cleared", {data_ready, rxrdy_n}, 2'b01);
    push(8'hD9);
    chk(head_data == 8'hD9, "R10 new head", head_data, 8'hD9);
    drain("R10");

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule